// File: doc/BRIEF.md
# Configurable Logic Cell with Fusable Lookup Tables

This block models one programmable logic cell of a configurable fabric. A configuration word picks two 8-entry truth tables and a handful of mode bits. It is written through a strobe and held while the cell runs. The cell evaluates three operand bits through both tables, so it yields two independent 3-input functions of the same operands. Alternatively, the two tables can be fused into one 4-input function: a fourth operand then steers a 2-to-1 multiplexer between the two table outputs.

The lowest address bit can come from a front-end AND of two operands, which is the partial-product term of an array-multiplier cell. The highest address bit can come from the cell's own register, which gives a feedback path for counters and toggles. The register is a D flip-flop. A synchronous set/reset input forces it to a configured level and takes priority over data. Its data input is either the cell's primary result or a direct operand.

The register drives a tri-statable output. This is modelled as a separate data/enable pair, so no high-impedance net is needed.

A small controller tracks whether the cell has been configured. It has two states:
- `CELL_EMPTY` is entered at reset. Results are held quiet and the register does not clock.
- `CELL_LIVE` is active operation.

The transitions are:
- EMPTY to LIVE, taken on the first configuration write.
- LIVE to LIVE, taken on a later write, which reloads the word.
- any state to EMPTY, taken on the asynchronous reset `rst_n`.

Top module: `lcell_core`

## Requirements
- R1: A cycle with `cfg_we` high stores `cfg_wdata` at that clock edge, and the new word takes effect after the edge. The field positions are:
  - `[7:0]` table A, where entry i is the result for address i.
  - `[15:8]` table B.
  - `[16]` fuse.
  - `[17]` AND front-end enable.
  - `[18]` feedback enable.
  - `[19]` set/reset level.
  - `[20]` register bypass.
  - `[21]` output enable allow.
- R2: From reset until the first configuration write, the cell is quiet. `comb_x`, `comb_y`, `reg_q` and `qo_en` are all 0, and neither data nor `sr` changes the register.
- R3: When configured with fuse=0, `comb_x` is table A at address `{a2,a1,a0}` and `comb_y` is table B at the same address. By default a0=`in_a`, a1=`in_b` and a2=`in_c`.
- R4: With fuse=1, `comb_x` is table B at the address when `in_d`=1, and table A when `in_d`=0. `comb_y` stays table B.
- R5: With the AND enable=1, a0 is `in_a & in_m`. Otherwise `in_m` has no effect.
- R6: While configured, `sr`=1 at a clock edge loads the set/reset level bit into the register, whatever the data.
- R7: While configured and `sr`=0, each clock edge loads the register with `in_d` when bypass=1, and with `comb_x` otherwise.
- R8: `qo_data` equals `reg_q`. `qo_en` is 1 only when the cell is configured, the enable-allow bit is 1 and `oe`=1.
- R9: With feedback enable=1, a2 is the current `reg_q` in place of `in_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 22 | Configuration word |
| in_a | input | 1 | Operand, address bit 0 source |
| in_b | input | 1 | Operand, address bit 1 |
| in_c | input | 1 | Operand, address bit 2 source |
| in_d | input | 1 | Fourth operand / fuse select / bypass data |
| in_m | input | 1 | AND front-end partner operand |
| sr | input | 1 | Synchronous set/reset |
| oe | input | 1 | Output enable request |
| comb_x | output | 1 | Primary combinational result |
| comb_y | output | 1 | Secondary combinational result |
| reg_q | output | 1 | Register output |
| qo_data | output | 1 | Tri-state output data |
| qo_en | output | 1 | Tri-state output enable |

## Verification
The tables are swept over all eight addresses with a majority table in A and a parity table in B. This separates the two outputs and catches swapped or reversed address bits. The fused mode is swept over all sixteen operand combinations with an AND table against parity, so that a wrong polarity on the fuse select shows up. A pass-through table exercises the AND front end over all four `in_a`/`in_m` pairs. An inverting table on the feedback bit makes the register toggle, which proves that the feedback is taken in place of `in_c`. Set/reset is driven against opposing data at both levels, and output enables are tried with the allow bit both set and clear.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int CELL_K   = 3;
    localparam int TBL_SIZE = 1 << CELL_K;

    typedef enum logic {
        CELL_EMPTY = 1'b0,
        CELL_LIVE  = 1'b1
    } cell_state_t;

    // Declared MSB first; tbl_a ends at bit 0.
    typedef struct packed {
        logic                oe_allow;
        logic                d_bypass;
        logic                sr_level;
        logic                fb_en;
        logic                and_en;
        logic                fuse;
        logic [TBL_SIZE-1:0] tbl_b;
        logic [TBL_SIZE-1:0] tbl_a;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/lcell_frontend.sv
module lcell_frontend #(
    parameter int K = 3
) (
    input  logic [K-1:0] op_i,
    input  logic         and_partner_i,
    input  logic         and_en_i,
    input  logic         fb_i,
    input  logic         fb_en_i,
    output logic [K-1:0] addr_o
);
    // Bit 0 may be a partial product; the top bit may be the register.
    generate
        for (genvar i = 0; i < K; i++) begin : g_bit
            if (i == 0) begin : g_and
                assign addr_o[i] = and_en_i ? (op_i[i] & and_partner_i) : op_i[i];
            end else if (i == K-1) begin : g_fb
                assign addr_o[i] = fb_en_i ? fb_i : op_i[i];
            end else begin : g_pass
                assign addr_o[i] = op_i[i];
            end
        end
    endgenerate
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
    parameter int K = 3,
    localparam int DEPTH = 1 << K
) (
    input  logic [DEPTH-1:0] table_i,
    input  logic [K-1:0]     addr_i,
    output logic             bit_o
);
    // Binary mux tree, one level per address bit.
    logic [DEPTH-1:0] lvl [K+1];

    assign lvl[0] = table_i;

    generate
        for (genvar l = 0; l < K; l++) begin : g_lvl
            localparam int N = DEPTH >> (l + 1);
            for (genvar j = 0; j < DEPTH; j++) begin : g_node
                if (j < N) begin : g_mux
                    assign lvl[l+1][j] = addr_i[l] ? lvl[l][2*j+1] : lvl[l][2*j];
                end else begin : g_zero
                    assign lvl[l+1][j] = 1'b0;
                end
            end
        end
    endgenerate

    assign bit_o = lvl[K][0];
endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic sr_i,
    input  logic sr_level_i,
    input  logic d_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (run_i) begin
            if (sr_i) begin
                q_o <= sr_level_i;
            end else begin
                q_o <= d_i;
            end
        end
    end
endmodule

// File: rtl/lcell_core.sv
module lcell_core
    import lcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             in_a,
    input  logic             in_b,
    input  logic             in_c,
    input  logic             in_d,
    input  logic             in_m,
    input  logic             sr,
    input  logic             oe,
    output logic             comb_x,
    output logic             comb_y,
    output logic             reg_q,
    output logic             qo_data,
    output logic             qo_en
);
    cell_state_t state_q, state_d;
    cell_cfg_t   cfg_q;
    logic        live;
    logic [CELL_K-1:0] addr;
    logic [1:0]  tbl_bit;
    logic        fused_bit;
    logic        reg_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CELL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_EMPTY: if (cfg_we) state_d = CELL_LIVE;
            CELL_LIVE:  state_d = CELL_LIVE;
            default:    state_d = CELL_EMPTY;
        endcase
    end

    // Configuration holding register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    assign live = (state_q == CELL_LIVE);

    lcell_frontend #(.K(CELL_K)) u_front (
        .op_i          ({in_c, in_b, in_a}),
        .and_partner_i (in_m),
        .and_en_i      (cfg_q.and_en),
        .fb_i          (reg_q),
        .fb_en_i       (cfg_q.fb_en),
        .addr_o        (addr)
    );

    generate
        for (genvar t = 0; t < 2; t++) begin : g_tbl
            lcell_lut #(.K(CELL_K)) u_lut (
                .table_i ((t == 0) ? cfg_q.tbl_a : cfg_q.tbl_b),
                .addr_i  (addr),
                .bit_o   (tbl_bit[t])
            );
        end
    endgenerate

    // 2-to-1 mux: fourth operand picks the table in fused mode.
    assign fused_bit = cfg_q.fuse ? (in_d ? tbl_bit[1] : tbl_bit[0]) : tbl_bit[0];
    assign reg_d     = cfg_q.d_bypass ? in_d : fused_bit;

    lcell_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (live),
        .sr_i       (sr),
        .sr_level_i (cfg_q.sr_level),
        .d_i        (reg_d),
        .q_o        (reg_q)
    );

    // Outputs by state.
    always_comb begin
        comb_x  = 1'b0;
        comb_y  = 1'b0;
        qo_en   = 1'b0;
        qo_data = reg_q;
        unique case (state_q)
            CELL_EMPTY: ;
            CELL_LIVE: begin
                comb_x = fused_bit;
                comb_y = tbl_bit[1];
                qo_en  = cfg_q.oe_allow & oe;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lcell_core_chk.sv
module lcell_core_chk
    import lcell_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             in_d,
    input logic             sr,
    input logic             oe,
    input logic             comb_x,
    input logic             comb_y,
    input logic             reg_q,
    input logic             qo_en,
    input cell_state_t      state_q,
    input cell_cfg_t        cfg_q
);
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_wdata)));  // R1

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CELL_EMPTY) |-> (!comb_x && !comb_y && !qo_en && !reg_q));  // R2

    AST_FUSED_PICK_B: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CELL_LIVE && cfg_q.fuse && in_d) |-> (comb_x == comb_y));  // R4

    AST_SR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CELL_LIVE && sr) |=> (reg_q == $past(cfg_q.sr_level)));  // R6

    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        qo_en |-> (oe && cfg_q.oe_allow));  // R8
endmodule

bind lcell_core lcell_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .in_d      (in_d),
    .sr        (sr),
    .oe        (oe),
    .comb_x    (comb_x),
    .comb_y    (comb_y),
    .reg_q     (reg_q),
    .qo_en     (qo_en),
    .state_q   (state_q),
    .cfg_q     (cfg_q)
);

// File: tb/lcell_core_tb.sv
module lcell_core_tb;
    import lcell_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic in_a = 0, in_b = 0, in_c = 0, in_d = 0, in_m = 0, sr = 0, oe = 0;
    logic comb_x, comb_y, reg_q, qo_data, qo_en;

    always #2 clk = ~clk;  // 250 MHz

    lcell_core u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d), .in_m(in_m),
        .sr(sr), .oe(oe), .comb_x(comb_x), .comb_y(comb_y), .reg_q(reg_q),
        .qo_data(qo_data), .qo_en(qo_en)
    );

    typedef struct {
        logic [4:0] v;  // {comb_x, comb_y, reg_q, qo_data, qo_en}
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Bench model state.
    logic [CFG_W-1:0] m_cfg = '0;
    logic             m_live = 0;
    logic             m_q = 0;

    function automatic logic [CFG_W-1:0] mk(input logic [7:0] ta, input logic [7:0] tb,
        input logic fu, input logic an, input logic fb, input logic lv,
        input logic by, input logic oa);
        return {oa, by, lv, fb, an, fu, tb, ta};
    endfunction

    task automatic step(input logic a, input logic b, input logic c, input logic d,
                        input logic m, input logic s, input logic o,
                        input logic we, input logic [CFG_W-1:0] wd, input string tag);
        logic [7:0] ta, tb;
        logic a0, a2, x, y, qe;
        int ad;
        exp_t e;
        @(negedge clk);
        in_a = a; in_b = b; in_c = c; in_d = d; in_m = m; sr = s; oe = o;
        cfg_we = we; cfg_wdata = wd;
        ta = m_cfg[7:0];
        tb = m_cfg[15:8];
        a0 = m_cfg[17] ? (a & m) : a;
        a2 = m_cfg[18] ? m_q : c;
        ad = int'({a2, b, a0});
        y  = tb[ad];
        x  = (m_cfg[16] && d) ? tb[ad] : ta[ad];
        qe = m_cfg[21] & o;
        if (!m_live) begin x = 0; y = 0; qe = 0; end
        e.v = {x, y, m_q, m_q, qe};
        e.tag = tag;
        exp_q.push_back(e);
        if (m_live) m_q = s ? m_cfg[19] : (m_cfg[20] ? d : x);
        if (we) begin m_cfg = wd; m_live = 1; end
    endtask

    // Monitor: compare one item per cycle, between edges.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [4:0] act;
                e = exp_q.pop_front();
                act = {comb_x, comb_y, reg_q, qo_data, qo_en};
                n_cmp++;
                if (act !== e.v) begin
                    n_bad++;
                    $display("FAIL %s: got %b expected %b (x,y,q,qd,qe)", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2: unconfigured cell stays quiet, sr ignored.
        step(1, 1, 1, 1, 1, 0, 1, 0, '0, "R2 idle");
        step(1, 0, 1, 1, 0, 1, 1, 0, '0, "R2 sr ignored");
        step(0, 1, 0, 0, 1, 0, 1, 0, '0, "R2 idle2");
        // R1: load split config, majority in A, parity in B.
        step(0, 0, 0, 0, 0, 0, 0, 1, mk(8'hE8, 8'h96, 0, 0, 0, 0, 0, 1), "R1 load");
        // R3/R7/R8: sweep addresses, register follows comb_x.
        for (int i = 0; i < 8; i++)
            step(i[0], i[1], i[2], ~i[0], 1, 0, i[1], 0, '0, "R3 R7 R8 split sweep");
        // R4: fused AND3 vs parity over 16 combos.
        step(0, 0, 0, 0, 0, 0, 0, 1, mk(8'h80, 8'h96, 1, 0, 0, 0, 0, 1), "R1 reload");
        for (int i = 0; i < 16; i++)
            step(i[0], i[1], i[2], i[3], 0, 0, 1, 0, '0, "R4 fused sweep");
        // R5: AND front end with pass-through table on bit 0.
        step(0, 0, 0, 0, 0, 0, 0, 1, mk(8'hAA, 8'h55, 0, 1, 0, 0, 0, 0), "R1 and cfg");
        for (int i = 0; i < 4; i++)
            step(i[0], 0, 0, 0, i[1], 0, 1, 0, '0, "R5 and front");
        // R5: with AND disabled, in_m has no effect.
        step(0, 0, 0, 0, 0, 0, 0, 1, mk(8'hAA, 8'h55, 0, 0, 0, 0, 0, 0), "R5 and off cfg");
        step(1, 0, 0, 0, 0, 0, 0, 0, '0, "R5 m ignored");
        step(1, 0, 0, 0, 1, 0, 0, 0, '0, "R5 m ignored");
        // R7: bypass register data.
        step(0, 0, 0, 0, 0, 0, 0, 1, mk(8'h00, 8'h00, 0, 0, 0, 1, 1, 1), "R7 bypass cfg");
        step(0, 0, 0, 1, 0, 0, 1, 0, '0, "R7 bypass d1");
        step(0, 0, 0, 0, 0, 0, 1, 0, '0, "R7 bypass d0");
        step(0, 0, 0, 1, 0, 0, 1, 0, '0, "R7 bypass d1");
        // R6: sr level 1 against d=0.
        step(0, 0, 0, 0, 0, 1, 1, 0, '0, "R6 set");
        step(0, 0, 0, 0, 0, 0, 1, 0, '0, "R6 set seen");
        // R6: sr level 0 against d=1.
        step(0, 0, 0, 1, 0, 0, 1, 1, mk(8'hFF, 8'h00, 0, 0, 0, 0, 1, 1), "R6 lvl0 cfg");
        step(0, 0, 0, 1, 0, 1, 1, 0, '0, "R6 reset");
        step(0, 0, 0, 1, 0, 1, 1, 0, '0, "R6 reset seen");
        // R9: feedback with inverting table on a2 toggles the register.
        step(0, 0, 1, 0, 0, 0, 1, 1, mk(8'h0F, 8'hF0, 0, 0, 1, 0, 0, 1), "R9 fb cfg");
        for (int i = 0; i < 6; i++)
            step(0, 0, i[0], 0, 0, 0, 1, 0, '0, "R9 toggle");
        // R8: allow bit clear blocks the enable.
        step(0, 0, 0, 0, 0, 0, 1, 1, mk(8'h0F, 8'hF0, 0, 0, 1, 0, 0, 0), "R8 allow off cfg");
        step(0, 0, 0, 0, 0, 0, 1, 0, '0, "R8 enable blocked");
        step(0, 0, 0, 0, 0, 0, 1, 0, '0, "R8 enable blocked");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule